// File: doc/BRIEF.md
# Processor Execution State Controller

This block follows which of four execution states a processor core occupies and decides every move between them from single-cycle event inputs. The core runs instructions in the run state. It takes exceptions for interrupts, traps, trace, bus errors, privilege violations and a software reset event. It ends up halted when a second bus error arrives while a bus-error exception is still being handled. It can also be parked in a debug state by a breakpoint or a dedicated debug-entry instruction.

The block also holds the privilege bit, which selects the stack pointer, and a low-power standby flag. The standby flag is set by a stop request in supervisor level. It is cleared only by an interrupt at or above a programmed wake level, by a level-7 interrupt, or by the reset event. All decisions are registered, so every output changes one clock after the event that caused it.

Top module: `cpu_state_ctl`

## Requirements
- R1: After `rst_n` is released, `state_o` is 1 (exception), `sup_o` is 1 and `lowpower_o` is 0. The state encoding is 0 = run, 1 = exception, 2 = halted, 3 = debug.
- R2: In the run state, any of the following moves the state to exception on the next clock and sets `sup_o` to 1: `trap`, `trace`, a nonzero `irq_lvl`, or `bus_err`.
- R3: In the exception state, `exc_done` with no bus error returns the state to run on the next clock.
- R4: A bus error during an exception that was itself entered by a bus error is a double fault. It moves the state to debug (3) if `dbg_en` is 1, and to halted (2) if `dbg_en` is 0. A bus error during any other exception keeps the state at exception and arms double-fault detection.
- R5: The halted state ignores every input except `reset_evt`.
- R6: In the run state, `bkpt` or `dbg_insn` moves the state to debug and takes priority over every other run-state event. In the debug state, `dbg_resume` returns the state to run.
- R7: `stop_req` in run state at supervisor level sets `lowpower_o` and leaves the state at run. `stop_req` at user level is a privilege violation and moves the state to exception.
- R8: While `lowpower_o` is 1, the core wakes only on a nonzero `irq_lvl` that is either greater than or equal to `wake_lvl`, or equal to 7. Waking clears `lowpower_o` and moves the state to exception. All other events leave the standby condition unchanged.
- R9: `reset_evt` has the highest priority from every state, including halted and standby. On the next clock the state is exception, `sup_o` is 1 and `lowpower_o` is 0.
- R10: `sp_sel_o` is 1 (supervisor stack) exactly when `sup_o` is 1. In the run state with no other event, `sr_wr` loads `sr_s` into the privilege bit.
- R11: `priv_insn` at user level moves the state to exception. At supervisor level it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| reset_evt | input | 1 | Core reset event, highest priority |
| irq_lvl | input | 3 | Pending interrupt level, 0 = none |
| wake_lvl | input | 3 | Programmed minimum level that ends standby |
| trap | input | 1 | Trap instruction event |
| trace | input | 1 | Trace condition event |
| bus_err | input | 1 | Bus error event |
| bkpt | input | 1 | Breakpoint event |
| dbg_insn | input | 1 | Debug-entry instruction event |
| dbg_resume | input | 1 | Leave the debug state |
| dbg_en | input | 1 | Double fault goes to debug (1) or halted (0) |
| stop_req | input | 1 | Low-power stop request |
| priv_insn | input | 1 | Privileged instruction attempted |
| exc_done | input | 1 | Exception sequence finished |
| sr_wr | input | 1 | Write the privilege bit |
| sr_s | input | 1 | Value written by `sr_wr` |
| state_o | output | 2 | Current execution state |
| sup_o | output | 1 | Privilege bit, 1 = supervisor |
| sp_sel_o | output | 1 | Stack select, 1 = supervisor stack |
| lowpower_o | output | 1 | Standby condition active |

## Verification
Several properties are checked on every cycle:
- the reset event leads to a supervisor exception state;
- the halted state holds without a reset event;
- the double fault resolves according to the debug-enable input;
- every entry into exception is in supervisor level;
- standby persists until the wake comparator fires;
- standby occurs only in the run state.

Some behaviour only the bench scenarios can show: the full wake-level table over all 64 interrupt/wake pairs, the priority of debug entry over other run-state events, the difference between a first and a second bus error, and privilege-dependent handling of stop and privileged instructions.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_EXC   = 2'd1,
        PS_HALT  = 2'd2,
        PS_DEBUG = 2'd3
    } pstate_t;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_DEBUG = 3'd1,
        ACT_BERR  = 3'd2,
        ACT_EXC   = 3'd3,
        ACT_STOP  = 3'd4,
        ACT_SRWR  = 3'd5
    } run_act_t;

    typedef struct packed {
        pstate_t st;
        logic    sup;
        logic    stop;
        logic    berr;
    } ctl_t;

endpackage

// File: rtl/cpu_state_wake.sv
module cpu_state_wake #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0] wake_lvl,
    output logic             wake_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    always_comb begin
        wake_o = (irq_lvl != '0) && ((irq_lvl >= wake_lvl) || (irq_lvl == LVL_MAX));
    end
endmodule

// File: rtl/cpu_state_runsel.sv
module cpu_state_runsel
    import cpu_state_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic             trap,
    input  logic             trace,
    input  logic             bus_err,
    input  logic             bkpt,
    input  logic             dbg_insn,
    input  logic             stop_req,
    input  logic             priv_insn,
    input  logic             sr_wr,
    input  logic             sup,
    output run_act_t         act_o
);
    always_comb begin
        act_o = ACT_NONE;
        if (bkpt || dbg_insn)
            act_o = ACT_DEBUG;
        else if (bus_err)
            act_o = ACT_BERR;
        else if (trap || trace || (irq_lvl != '0) || (priv_insn && !sup) || (stop_req && !sup))
            act_o = ACT_EXC;
        else if (stop_req)
            act_o = ACT_STOP;
        else if (sr_wr)
            act_o = ACT_SRWR;
    end
endmodule

// File: rtl/cpu_state_ctl.sv
module cpu_state_ctl
    import cpu_state_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_evt,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0] wake_lvl,
    input  logic             trap,
    input  logic             trace,
    input  logic             bus_err,
    input  logic             bkpt,
    input  logic             dbg_insn,
    input  logic             dbg_resume,
    input  logic             dbg_en,
    input  logic             stop_req,
    input  logic             priv_insn,
    input  logic             exc_done,
    input  logic             sr_wr,
    input  logic             sr_s,
    output logic [1:0]       state_o,
    output logic             sup_o,
    output logic             sp_sel_o,
    output logic             lowpower_o
);
    localparam ctl_t CTL_RST = '{st: PS_EXC, sup: 1'b1, stop: 1'b0, berr: 1'b0};

    ctl_t     ctl_d, ctl_q;
    logic     wake;
    run_act_t act;

    cpu_state_wake #(.LVL_W(LVL_W)) u_wake (
        .irq_lvl (irq_lvl),
        .wake_lvl(wake_lvl),
        .wake_o  (wake)
    );

    cpu_state_runsel #(.LVL_W(LVL_W)) u_runsel (
        .irq_lvl  (irq_lvl),
        .trap     (trap),
        .trace    (trace),
        .bus_err  (bus_err),
        .bkpt     (bkpt),
        .dbg_insn (dbg_insn),
        .stop_req (stop_req),
        .priv_insn(priv_insn),
        .sr_wr    (sr_wr),
        .sup      (ctl_q.sup),
        .act_o    (act)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reset_evt) begin
            ctl_d = CTL_RST;
        end else begin
            unique case (ctl_q.st)
                PS_HALT: ctl_d = ctl_q;
                PS_DEBUG: begin
                    if (dbg_resume) ctl_d.st = PS_RUN;
                end
                PS_EXC: begin
                    if (bus_err && ctl_q.berr) begin
                        ctl_d.st   = dbg_en ? PS_DEBUG : PS_HALT;
                        ctl_d.berr = 1'b0;
                    end else if (bus_err) begin
                        ctl_d.berr = 1'b1;
                    end else if (exc_done) begin
                        ctl_d.st   = PS_RUN;
                        ctl_d.berr = 1'b0;
                    end
                end
                default: begin
                    if (ctl_q.stop) begin
                        if (wake) begin
                            ctl_d.stop = 1'b0;
                            ctl_d.st   = PS_EXC;
                            ctl_d.sup  = 1'b1;
                        end
                    end else begin
                        unique case (act)
                            ACT_DEBUG: ctl_d.st = PS_DEBUG;
                            ACT_BERR: begin
                                ctl_d.st   = PS_EXC;
                                ctl_d.sup  = 1'b1;
                                ctl_d.berr = 1'b1;
                            end
                            ACT_EXC: begin
                                ctl_d.st  = PS_EXC;
                                ctl_d.sup = 1'b1;
                            end
                            ACT_STOP: ctl_d.stop = 1'b1;
                            ACT_SRWR: ctl_d.sup  = sr_s;
                            default:  ctl_d = ctl_q;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign state_o    = ctl_q.st;
    assign sup_o      = ctl_q.sup;
    assign sp_sel_o   = ctl_q.sup;
    assign lowpower_o = ctl_q.stop;

    // R9: reset event wins from any state
    a_r9_reset_evt: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt |=> (state_o == 2'd1) && sup_o && !lowpower_o);

    // R5: halted is sticky without a reset event
    a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) && !reset_evt |=> (state_o == 2'd2));

    // R4: double fault resolution
    a_r4_double_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) && ctl_q.berr && bus_err && !reset_evt
        |=> (state_o == ($past(dbg_en) ? 2'd3 : 2'd2)));

    // R2: exception is always entered in supervisor level
    a_r2_exc_sup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd1) ##1 (state_o == 2'd1) |-> sup_o);

    // R8: standby persists until the wake comparator fires
    a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lowpower_o && !wake && !reset_evt |=> lowpower_o);

    // R7: standby only occurs in the run state
    a_r7_lp_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        lowpower_o |-> (state_o == 2'd0));
endmodule

// File: tb/cpu_state_ctl_test.sv
module cpu_state_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reset_evt, trap, trace, bus_err, bkpt, dbg_insn, dbg_resume, dbg_en;
    logic       stop_req, priv_insn, exc_done, sr_wr, sr_s;
    logic [2:0] irq_lvl, wake_lvl;
    logic [1:0] state_o;
    logic       sup_o, sp_sel_o, lowpower_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    cpu_state_ctl uut (
        .clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .irq_lvl(irq_lvl),
        .wake_lvl(wake_lvl), .trap(trap), .trace(trace), .bus_err(bus_err),
        .bkpt(bkpt), .dbg_insn(dbg_insn), .dbg_resume(dbg_resume), .dbg_en(dbg_en),
        .stop_req(stop_req), .priv_insn(priv_insn), .exc_done(exc_done),
        .sr_wr(sr_wr), .sr_s(sr_s), .state_o(state_o), .sup_o(sup_o),
        .sp_sel_o(sp_sel_o), .lowpower_o(lowpower_o)
    );

    task automatic clr();
        reset_evt = 0; trap = 0; trace = 0; bus_err = 0; bkpt = 0; dbg_insn = 0;
        dbg_resume = 0; stop_req = 0; priv_insn = 0; exc_done = 0; sr_wr = 0;
        sr_s = 0; irq_lvl = 3'd0;
    endtask

    // inputs set at a falling edge are taken at the next rising edge,
    // results are sampled at the following falling edge
    task automatic cyc();
        @(negedge clk);
        clr();
    endtask

    task automatic chk(string req, logic [1:0] est, logic esup, logic elp);
        n_chk++;
        if (state_o !== est || sup_o !== esup || lowpower_o !== elp || sp_sel_o !== esup) begin
            n_fail++;
            $display("FAIL %s: state/sup/sp/lp = %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                     req, state_o, sup_o, sp_sel_o, lowpower_o, est, esup, esup, elp);
        end
    endtask

    task automatic to_run(logic user);
        reset_evt = 1; cyc();
        exc_done = 1; cyc();
        if (user) begin sr_wr = 1; sr_s = 0; cyc(); end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr(); dbg_en = 0; wake_lvl = 3'd0;
        repeat (2) @(negedge clk);
        chk("R1 reset", 2'd1, 1, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", 2'd1, 1, 0);

        // R3 exception returns to run
        exc_done = 1; cyc();
        chk("R3 exc_done", 2'd0, 1, 0);

        // R10 privilege write
        sr_wr = 1; sr_s = 0; cyc();
        chk("R10 sr write user", 2'd0, 0, 0);
        sr_wr = 1; sr_s = 1; cyc();
        chk("R10 sr write sup", 2'd0, 1, 0);

        // R2 each exception source from user level
        for (int e = 0; e < 4; e++) begin
            to_run(1);
            chk("R10 user level", 2'd0, 0, 0);
            case (e)
                0: trap = 1;
                1: trace = 1;
                2: irq_lvl = 3'd2;
                default: bus_err = 1;
            endcase
            cyc();
            chk("R2 exception entry", 2'd1, 1, 0);
        end

        // R6 debug entry has priority
        to_run(1);
        bkpt = 1; trap = 1; bus_err = 1; irq_lvl = 3'd7; cyc();
        chk("R6 bkpt priority", 2'd3, 0, 0);
        trap = 1; cyc();
        chk("R6 debug holds", 2'd3, 0, 0);
        dbg_resume = 1; cyc();
        chk("R6 resume", 2'd0, 0, 0);
        dbg_insn = 1; stop_req = 1; cyc();
        chk("R6 debug insn", 2'd3, 0, 0);

        // R11 privileged instruction
        to_run(0);
        priv_insn = 1; cyc();
        chk("R11 priv in sup ignored", 2'd0, 1, 0);
        to_run(1);
        priv_insn = 1; cyc();
        chk("R11 priv in user", 2'd1, 1, 0);

        // R7 stop in user is a violation
        to_run(1);
        stop_req = 1; cyc();
        chk("R7 stop in user", 2'd1, 1, 0);

        // R4 double fault both ways, and a non-bus-error exception
        for (int b = 0; b < 2; b++) begin
            dbg_en = b[0];
            to_run(0);
            bus_err = 1; cyc();
            chk("R4 first bus error", 2'd1, 1, 0);
            bus_err = 1; cyc();
            chk("R4 double fault", b ? 2'd3 : 2'd2, 1, 0);
        end
        dbg_en = 0;
        to_run(0);
        trap = 1; cyc();
        bus_err = 1; cyc();
        chk("R4 bus error in trap exception", 2'd1, 1, 0);
        bus_err = 1; cyc();
        chk("R4 second bus error halts", 2'd2, 1, 0);

        // R5 halted ignores everything but reset_evt
        trap = 1; trace = 1; bus_err = 1; bkpt = 1; dbg_insn = 1; dbg_resume = 1;
        stop_req = 1; exc_done = 1; sr_wr = 1; irq_lvl = 3'd7; cyc();
        chk("R5 halted ignores", 2'd2, 1, 0);
        reset_evt = 1; cyc();
        chk("R9 reset from halted", 2'd1, 1, 0);

        // R8 exhaustive wake table
        for (int w = 0; w < 8; w++) begin
            for (int i = 0; i < 8; i++) begin
                logic exp_wake;
                to_run(0);
                stop_req = 1; cyc();
                chk("R7 stop in sup", 2'd0, 1, 1);
                wake_lvl = w[2:0];
                trap = 1; exc_done = 1; sr_wr = 1; sr_s = 0; bkpt = 1;
                cyc();
                chk("R8 other events ignored", 2'd0, 1, 1);
                irq_lvl = i[2:0]; cyc();
                exp_wake = (i != 0) && (i >= w || i == 7);
                chk("R8 wake table", exp_wake ? 2'd1 : 2'd0, 1, !exp_wake);
            end
        end

        // R9 reset from standby and from debug
        to_run(0);
        stop_req = 1; cyc();
        wake_lvl = 3'd6; irq_lvl = 3'd1; reset_evt = 1; cyc();
        chk("R9 reset from stop", 2'd1, 1, 0);
        to_run(1);
        bkpt = 1; cyc();
        reset_evt = 1; cyc();
        chk("R9 reset from debug", 2'd1, 1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule